// File: doc/BRIEF.md
# Quad serial SRAM byte access controller

This block sits between a simple host request interface and an external serial SRAM. It performs one byte read or one byte write per request over a four-bit quad data bus. The memory powers up expecting single-bit serial commands. On the first request after reset, the controller therefore sends the enter-quad command serially on data line 0 in a frame of its own, and then records that the memory is in quad mode. Every access after that uses the four-bit bus for the command, the address and the data.

The serial clock is divided down from the system clock and idles low. Outputs change only while it is low. Read nibbles are captured at its rising edge. Between frames, chip select stays high for a minimum gap. A request is accepted only when the controller is idle. Completion is signalled by a single-cycle done pulse, and the read data is valid in that cycle.

Top module: `qspi_ram_ctrl`

## Requirements
- R1: Under reset and right after it, chip select is high, the serial clock is low, all four output enables are 0 and done is 0.
- R2: The first request after reset is preceded by a frame of exactly 8 serial clocks. In that frame the value 0x38 is shifted out on data line 0, most significant bit first, with output enable pattern 4'b0001. Chip select then goes high.
- R3: The enter-quad frame is sent only once after reset. Later requests go straight to quad-mode access frames.
- R4: A read frame has 12 serial clocks. Clocks 1-2 carry command 0x03, upper nibble first. Clocks 3-8 carry address bits 23:20 down to 3:0. Clocks 9-10 are dummy clocks with all enables 0. Clocks 11-12 capture read bits 7:4 and then 3:0 from the bus. The captured byte appears on the read data output.
- R5: A write frame has 10 serial clocks with all four enables 1. Clocks 1-2 carry command 0x02, clocks 3-8 carry the address as in R4, and clocks 9-10 carry write bits 7:4 and then 3:0.
- R6: The serial clock is low whenever chip select is high. Chip select therefore falls before the first clock of a frame and rises after the last one.
- R7: All output enables are 0 whenever chip select is high. After the last clock of any frame, the data lines are released before chip select rises.
- R8: The data outputs and output enables do not change while the serial clock is high.
- R9: A request raised while a transaction is in progress is ignored. It starts no frame and changes no memory location.
- R10: Done is high for exactly one system clock per accepted request, and read data is valid in that cycle.
- R11: Between any two frames, chip select stays high for at least 2 serial clock periods (4*HALF_DIV system clocks).
- R12: Within a frame, consecutive rising edges of the serial clock are 2*HALF_DIV system clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, taken only when idle |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 24 | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid while done_o is high |
| done_o | output | 1 | One-cycle completion pulse |
| cs_n_o | output | 1 | Memory chip select, active low |
| sclk_o | output | 1 | Serial clock, idles low |
| dq_o | output | 4 | Data driven to the memory |
| dq_oe_o | output | 4 | Per-line output enable |
| dq_i | input | 4 | Data read from the memory |

## Verification
The assertions assume that req_i, wr_i, addr_i and wdata_i are synchronous to clk_i. They also assume that the memory drives dq_i only while all four enables are low, and that it holds each read nibble from the falling serial clock edge through the next rising edge. The bench model of the memory changes its outputs only at the falling edges of the serial clock and only in the two data slots of a read frame. It counts any overlap with the host's enables as a violation. All host inputs change at falling system clock edges, and the one request sent during a busy frame is placed in the middle of the address phase.

// File: rtl/qspi_ram_pkg.sv
`timescale 1ns/1ps
package qspi_ram_pkg;
  localparam int NIB_W = 4;
  localparam int CMD_W = 8;
  localparam logic [CMD_W-1:0] CMD_ENTER_QUAD = 8'h38;
  localparam logic [CMD_W-1:0] CMD_READ       = 8'h03;
  localparam logic [CMD_W-1:0] CMD_WRITE      = 8'h02;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_TAIL,
    ST_GAP
  } seq_st_e;
endpackage

// File: rtl/qspi_ram_clkdiv.sv
`timescale 1ns/1ps
module qspi_ram_clkdiv #(
  parameter int HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == CW'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/qspi_ram_beat.sv
`timescale 1ns/1ps
// Maps a beat index within a frame to the nibble, enables and slot flags.
module qspi_ram_beat
  import qspi_ram_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8,
  parameter int DUMMY  = 2,
  parameter int BW     = 4
) (
  input  logic              acc_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [BW-1:0]     beat_i,
  output logic [NIB_W-1:0]  nib_o,
  output logic [NIB_W-1:0]  oe_o,
  output logic              last_o,
  output logic              sample_o
);
  localparam int CMD_N   = CMD_W / NIB_W;
  localparam int ADDR_N  = ADDR_W / NIB_W;
  localparam int DATA_N  = DATA_W / NIB_W;
  localparam int ADDR_LO = CMD_N;
  localparam int DATA_LO = CMD_N + ADDR_N;
  localparam int RD_LO   = DATA_LO + DUMMY;
  localparam int WR_LAST = DATA_LO + DATA_N - 1;
  localparam int RD_LAST = RD_LO + DATA_N - 1;
  localparam int SER_LAST = CMD_W - 1;

  logic [CMD_W-1:0] cmd;
  assign cmd = wr_i ? CMD_WRITE : CMD_READ;

  always_comb begin
    int b;
    int k;
    b        = int'(beat_i);
    k        = 0;
    nib_o    = '0;
    oe_o     = '0;
    last_o   = 1'b0;
    sample_o = 1'b0;
    if (!acc_i) begin
      // serial enter-quad frame, MSB first on line 0
      nib_o  = {3'b000, CMD_ENTER_QUAD[3'd7 - beat_i[2:0]]};
      oe_o   = 4'b0001;
      last_o = (b == SER_LAST);
    end else if (b < ADDR_LO) begin
      k     = CMD_N - 1 - b;
      nib_o = cmd[NIB_W*k +: NIB_W];
      oe_o  = '1;
    end else if (b < DATA_LO) begin
      k     = ADDR_N - 1 - (b - ADDR_LO);
      nib_o = addr_i[NIB_W*k +: NIB_W];
      oe_o  = '1;
    end else if (wr_i) begin
      k      = DATA_N - 1 - (b - DATA_LO);
      nib_o  = wdata_i[NIB_W*k +: NIB_W];
      oe_o   = '1;
      last_o = (b == WR_LAST);
    end else begin
      sample_o = (b >= RD_LO);
      last_o   = (b == RD_LAST);
    end
  end
endmodule

// File: rtl/qspi_ram_seq.sv
`timescale 1ns/1ps
module qspi_ram_seq
  import qspi_ram_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int DATA_W   = 8,
  parameter int BW       = 4,
  parameter int GAP_SCLK = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NIB_W-1:0]  dq_i,
  input  logic              last_i,
  input  logic              sample_i,
  output logic              run_o,
  output logic              shift_o,
  output logic              acc_o,
  output logic              wr_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [BW-1:0]     beat_o,
  output logic              cs_n_o,
  output logic              sclk_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o
);
  localparam int GAP_PH = 2 * GAP_SCLK;
  localparam int GW     = $clog2(GAP_PH + 1);

  seq_st_e           st_q;
  logic              phase_q;
  logic [BW-1:0]     beat_q;
  logic [GW-1:0]     gap_q;
  logic              quad_q;
  logic              acc_q;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              done_q;
  logic              cs_n_q;
  logic              sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      phase_q <= 1'b0;
      beat_q  <= '0;
      gap_q   <= '0;
      quad_q  <= 1'b0;
      acc_q   <= 1'b0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      sclk_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (req_i) begin
          wr_q    <= wr_i;
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
          acc_q   <= quad_q;   // still serial: send enter-quad frame first
          beat_q  <= '0;
          phase_q <= 1'b0;
          cs_n_q  <= 1'b0;
          st_q    <= ST_SHIFT;
        end
        ST_SHIFT: if (tick_i) begin
          if (!phase_q) begin
            sclk_q  <= 1'b1;
            phase_q <= 1'b1;
            if (sample_i) rdata_q <= {rdata_q[DATA_W-NIB_W-1:0], dq_i};
          end else begin
            sclk_q  <= 1'b0;
            phase_q <= 1'b0;
            if (last_i) st_q   <= ST_TAIL;
            else        beat_q <= beat_q + 1'b1;
          end
        end
        ST_TAIL: if (tick_i) begin
          cs_n_q <= 1'b1;
          gap_q  <= '0;
          st_q   <= ST_GAP;
          if (acc_q) done_q <= 1'b1;
          else       quad_q <= 1'b1;
        end
        ST_GAP: if (tick_i) begin
          if (gap_q == GW'(GAP_PH - 1)) begin
            if (!acc_q) begin
              acc_q   <= 1'b1;
              beat_q  <= '0;
              phase_q <= 1'b0;
              cs_n_q  <= 1'b0;
              st_q    <= ST_SHIFT;
            end else begin
              st_q <= ST_IDLE;
            end
          end else begin
            gap_q <= gap_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign run_o   = (st_q != ST_IDLE);
  assign shift_o = (st_q == ST_SHIFT);
  assign acc_o   = acc_q;
  assign wr_o    = wr_q;
  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign beat_o  = beat_q;
  assign cs_n_o  = cs_n_q;
  assign sclk_o  = sclk_q;
  assign rdata_o = rdata_q;
  assign done_o  = done_q;

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  // R3
  quad_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quad_q |=> quad_q);

  // R3
  serial_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cs_n_q) && !acc_q) |-> !quad_q);
endmodule

// File: rtl/qspi_ram_ctrl.sv
`timescale 1ns/1ps
module qspi_ram_ctrl
  import qspi_ram_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int DATA_W   = 8,
  parameter int HALF_DIV = 2,
  parameter int DUMMY    = 2,
  parameter int GAP_SCLK = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o,
  output logic              cs_n_o,
  output logic              sclk_o,
  output logic [3:0]        dq_o,
  output logic [3:0]        dq_oe_o,
  input  logic [3:0]        dq_i
);
  localparam int MAX_BEATS = (CMD_W + ADDR_W + DATA_W) / NIB_W + DUMMY;
  localparam int BW        = $clog2((MAX_BEATS > CMD_W) ? MAX_BEATS : CMD_W);
  localparam int GAP_MIN   = 4 * GAP_SCLK * HALF_DIV / 2;

  logic              tick;
  logic              run;
  logic              shift;
  logic              acc;
  logic              wr;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata;
  logic [BW-1:0]     beat;
  logic [NIB_W-1:0]  nib;
  logic [NIB_W-1:0]  oe;
  logic              last;
  logic              sample;

  qspi_ram_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
    .clk_i, .rst_ni, .run_i(run), .tick_o(tick)
  );

  qspi_ram_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BW(BW), .GAP_SCLK(GAP_SCLK)
  ) u_seq (
    .clk_i, .rst_ni, .tick_i(tick), .req_i, .wr_i, .addr_i, .wdata_i, .dq_i,
    .last_i(last), .sample_i(sample), .run_o(run), .shift_o(shift),
    .acc_o(acc), .wr_o(wr), .addr_o(addr), .wdata_o(wdata), .beat_o(beat),
    .cs_n_o, .sclk_o, .rdata_o, .done_o
  );

  qspi_ram_beat #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DUMMY(DUMMY), .BW(BW)
  ) u_beat (
    .acc_i(acc), .wr_i(wr), .addr_i(addr), .wdata_i(wdata), .beat_i(beat),
    .nib_o(nib), .oe_o(oe), .last_o(last), .sample_o(sample)
  );

  // lines are driven only during the shift phase; tail and gap release them
  assign dq_o    = shift ? nib : '0;
  assign dq_oe_o = shift ? oe  : '0;

  // cycles chip select has been high, saturating
  logic [15:0] hi_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 hi_cnt_q <= '1;
    else if (!cs_n_o)            hi_cnt_q <= '0;
    else if (hi_cnt_q != '1)     hi_cnt_q <= hi_cnt_q + 1'b1;
  end

  // R6
  idle_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o |-> !sclk_o);

  // R7
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o |-> (dq_oe_o == '0));

  // R8
  hold_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> ($stable(dq_o) && $stable(dq_oe_o)));

  // R11
  cs_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_n_o) |-> (hi_cnt_q >= 16'(GAP_MIN)));
endmodule

// File: tb/qspi_ram_ctrl_test.sv
`timescale 1ns/1ps
module qspi_ram_ctrl_test;
  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        wr_s = 1'b0;
  logic [23:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        done;
  logic        cs_n;
  logic        sclk;
  logic [3:0]  dq_o;
  logic [3:0]  dq_oe;
  logic [3:0]  dq_i;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  qspi_ram_ctrl #(.HALF_DIV(HALF)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wr_i(wr_s), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .done_o(done), .cs_n_o(cs_n),
    .sclk_o(sclk), .dq_o(dq_o), .dq_oe_o(dq_oe), .dq_i(dq_i)
  );

  // ---------------- memory model ----------------
  logic [7:0]  mem [0:255];
  logic [3:0]  nib [0:15];
  logic [7:0]  sh8 = '0;
  bit          quad_m = 0;
  bit          is_rd = 0;
  int          m_edges = 0;
  logic [3:0]  mdrv = '0;
  bit          mdrv_en = 0;
  int          mode_frames = 0;
  int          frames = 0;
  logic [7:0]  first_bits = '0;
  int          first_edges = 0;
  int          last_edges = 0;
  logic [7:0]  last_cmd = '0;
  logic [23:0] last_addr = '0;
  logic [7:0]  last_wdata = '0;
  int          viol_bus = 0;
  int          viol_ser = 0;

  initial for (int i = 0; i < 256; i++) mem[i] = 8'h00;

  always_comb
    for (int i = 0; i < 4; i++)
      dq_i[i] = dq_oe[i] ? dq_o[i] : (mdrv_en ? mdrv[i] : 1'b0);

  always @(negedge cs_n) if (rst_n) begin
    m_edges = 0;
    is_rd   = 0;
    mdrv_en = 0;
  end

  always @(posedge sclk) if (rst_n && !cs_n) begin
    if (!quad_m) begin
      sh8 = {sh8[6:0], dq_o[0]};
      if (dq_oe != 4'b0001) viol_ser++;
    end else begin
      if (m_edges < 16) nib[m_edges] = dq_o;
      if (m_edges == 1) is_rd = ({nib[0], dq_o} == 8'h03);
      if (m_edges < 8 || (!is_rd && m_edges < 10)) begin
        if (dq_oe != 4'hF) viol_bus++;
      end else if (dq_oe != 4'h0) viol_bus++;
      if (mdrv_en && dq_oe != 4'h0) viol_bus++;
    end
    m_edges++;
  end

  always @(negedge sclk) if (rst_n && !cs_n && quad_m && is_rd) begin
    if (m_edges == 10) begin
      mdrv    = mem[{nib[6], nib[7]}][7:4];
      mdrv_en = 1;
    end else if (m_edges == 11) begin
      mdrv = mem[{nib[6], nib[7]}][3:0];
    end
  end

  always @(posedge cs_n) if (rst_n) begin
    mdrv_en = 0;
    if (!quad_m) begin
      mode_frames++;
      if (mode_frames == 1) begin
        first_bits  = sh8;
        first_edges = m_edges;
      end
      if (m_edges == 8 && sh8 == 8'h38) quad_m = 1;
    end else begin
      frames++;
      last_edges = m_edges;
      last_cmd   = {nib[0], nib[1]};
      last_addr  = {nib[2], nib[3], nib[4], nib[5], nib[6], nib[7]};
      last_wdata = {nib[8], nib[9]};
      if (last_cmd == 8'h02 && m_edges == 10) mem[last_addr[7:0]] = last_wdata;
    end
  end

  // ---------------- protocol monitors ----------------
  logic       p_sclk = 1'b0;
  logic       p_cs = 1'b1;
  logic [3:0] p_dq = '0;
  logic [3:0] p_oe = '0;
  int  v_r6 = 0, v_r7 = 0, v_r8 = 0, v_r11 = 0, v_r12 = 0;
  int  since = 0, rises = 0, hi = 0, gaps = 0, dones = 0;
  bit  have_rise = 0, seen_frame = 0;

  always @(negedge clk) if (rst_n) begin
    if (cs_n && sclk) v_r6++;
    if (cs_n && dq_oe != 4'h0) v_r7++;
    if (sclk && (dq_o != p_dq || dq_oe != p_oe)) v_r8++;
    if (done) dones++;
    since++;
    if (sclk && !p_sclk) begin
      if (have_rise) begin
        rises++;
        if (since != 2 * HALF) v_r12++;
      end
      have_rise = 1;
      since     = 0;
    end
    if (cs_n) hi++;
    if (p_cs && !cs_n) begin
      if (seen_frame) begin
        gaps++;
        if (hi < 4 * HALF) v_r11++;
      end
      seen_frame = 1;
      have_rise  = 0;
      hi         = 0;
    end
    p_sclk = sclk;
    p_cs   = cs_n;
    p_dq   = dq_o;
    p_oe   = dq_oe;
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_access(input bit w, input logic [23:0] a,
                           input logic [7:0] d, output logic [7:0] rd);
    int  n;
    bit  seen;
    @(negedge clk);
    req = 1'b1; wr_s = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0;
    n = 0; seen = 0;
    while (!seen && n < 5000) begin
      if (done) seen = 1;
      else begin
        @(negedge clk);
        n++;
      end
    end
    rd = rdata;
    chk(seen, "R10 done arrives", 32'(seen), 1);
    @(negedge clk);
    chk(!done, "R10 done lasts one cycle", 32'(done), 0);
    repeat (4 * HALF + 4) @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(cs_n === 1'b1 && sclk === 1'b0, "R1 cs/sclk in reset", {cs_n, sclk}, 2'b10);
    chk(dq_oe === 4'h0 && done === 1'b0, "R1 oe/done in reset", {dq_oe, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n === 1'b1 && sclk === 1'b0, "R1 cs/sclk after reset", {cs_n, sclk}, 2'b10);
    chk(dq_oe === 4'h0 && done === 1'b0, "R1 oe/done after reset", {dq_oe, done}, 0);
  endtask

  task automatic t_first_write;
    logic [7:0] rd;
    do_access(1'b1, 24'h123456, 8'hA5, rd);
    chk(mode_frames == 1, "R2 one serial frame", mode_frames, 1);
    chk(first_bits == 8'h38, "R2 serial command", first_bits, 8'h38);
    chk(first_edges == 8, "R2 serial clocks", first_edges, 8);
    chk(viol_ser == 0, "R2 line 0 enable only", viol_ser, 0);
    chk(last_cmd == 8'h02, "R5 write command", last_cmd, 8'h02);
    chk(last_addr == 24'h123456, "R5 address nibbles", last_addr, 24'h123456);
    chk(last_wdata == 8'hA5, "R5 data nibbles", last_wdata, 8'hA5);
    chk(last_edges == 10, "R5 write clocks", last_edges, 10);
  endtask

  task automatic t_read_back;
    logic [7:0] rd;
    do_access(1'b0, 24'h123456, 8'h00, rd);
    chk(rd == 8'hA5, "R4 read data", rd, 8'hA5);
    chk(last_cmd == 8'h03, "R4 read command", last_cmd, 8'h03);
    chk(last_addr == 24'h123456, "R4 read address", last_addr, 24'h123456);
    chk(last_edges == 12, "R4 read clocks", last_edges, 12);
    chk(mode_frames == 1, "R3 no second serial frame", mode_frames, 1);
  endtask

  task automatic t_patterns;
    logic [7:0] rd;
    do_access(1'b1, 24'h00005A, 8'h3C, rd);
    chk(last_addr == 24'h00005A, "R5 low address", last_addr, 24'h00005A);
    do_access(1'b1, 24'hFFFFFF, 8'h81, rd);
    chk(last_wdata == 8'h81, "R5 data 81", last_wdata, 8'h81);
    do_access(1'b0, 24'h00005A, 8'h00, rd);
    chk(rd == 8'h3C, "R4 read 3C", rd, 8'h3C);
    do_access(1'b0, 24'hFFFFFF, 8'h00, rd);
    chk(rd == 8'h81, "R4 read 81", rd, 8'h81);
    chk(last_addr == 24'hFFFFFF, "R4 high address", last_addr, 24'hFFFFFF);
    chk(mode_frames == 1, "R3 still one serial frame", mode_frames, 1);
  endtask

  task automatic t_ignore_busy;
    logic [7:0] rd;
    int f0, d0;
    f0 = frames;
    d0 = dones;
    fork
      do_access(1'b1, 24'hABCDEF, 8'h11, rd);
      begin
        repeat (12 * HALF) @(negedge clk);
        req = 1'b1; wr_s = 1'b1; addr = 24'h000077; wdata = 8'hEE;
        @(negedge clk);
        req = 1'b0;
      end
    join
    repeat (100) @(negedge clk);
    chk(frames == f0 + 1, "R9 one frame only", frames - f0, 1);
    chk(dones == d0 + 1, "R10 one done per request", dones - d0, 1);
    chk(last_addr == 24'hABCDEF, "R9 frame used first request", last_addr, 24'hABCDEF);
    do_access(1'b0, 24'h000077, 8'h00, rd);
    chk(rd == 8'h00, "R9 ignored write left memory", rd, 8'h00);
    do_access(1'b0, 24'hABCDEF, 8'h00, rd);
    chk(rd == 8'h11, "R9 accepted write stored", rd, 8'h11);
  endtask

  task automatic t_protocol;
    chk(v_r6 == 0, "R6 clock low while deselected", v_r6, 0);
    chk(v_r7 == 0, "R7 released while deselected", v_r7, 0);
    chk(v_r8 == 0, "R8 outputs stable while clock high", v_r8, 0);
    chk(gaps > 0 && v_r11 == 0, "R11 deselect gap", v_r11, 0);
    chk(rises > 0 && v_r12 == 0, "R12 clock period", v_r12, 0);
    chk(viol_bus == 0, "R4 R5 enables and turnaround", viol_bus, 0);
  endtask

  initial begin
    t_reset();
    t_first_write();
    t_read_back();
    t_patterns();
    t_ignore_busy();
    t_protocol();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule